// File: doc/BRIEF.md
# Accelerator Instruction Trap Decider

This block decides, for a decoded single-copy 64-byte memory instruction, whether execution must be diverted to a higher privilege level. The instruction is one of three classes: plain 64-byte load/store, store-with-return, or store-with-zero-status. The block checks the class against two sets of per-class enable bits. The hypervisor set is held inside the block behind a write port. The guest-OS set arrives as an input.

A cleared guest-level bit at EL0 raises a trap to EL1. That trap takes priority over the hypervisor check. A cleared hypervisor bit raises a trap to EL2 at EL1. It does the same at EL0 when the guest level has not already trapped the instruction. When the host-mode bit pair is {1,1}, the whole check is skipped. When the effective-enable input is low, the stored hypervisor bits count as 0 for the decision, but a read still returns the stored value.

Every trap reports one exception class and a syndrome code that depends on the instruction class. The block is purely combinational from its inputs and its configuration register to its outputs.

Top module: `acc_trap_decider`

## Requirements
- R1: After reset with no EL3 present, the hypervisor enable bits read as 3'b000, so an EL1 plain load/store with the other conditions met traps to EL2.
- R2: A write (cfg_we_i high at a clock edge) stores cfg_wdata_i. The bits map as follows: bit 0 is store-with-zero-status, bit 1 is plain load/store, bit 2 is store-with-return. The stored value is visible on cfg_rdata_o from the next cycle and is unchanged while no write occurs.
- R3: At EL1 (el_i=1), trap_el2_o is high for a valid instruction whose hypervisor enable bit is 0, outside host mode and with eff_en_i high. The guest enables have no effect at EL1.
- R4: A hypervisor enable bit of 1 never causes a trap for its class.
- R5: At EL0 (el_i=0), a cleared guest bit (same bit mapping as R2) sets trap_el1_o and keeps trap_el2_o low. With the guest bit set, a cleared hypervisor bit sets trap_el2_o. The two trap outputs are never high together.
- R6: When host_mode_i is 2'b11, neither trap output is raised. Any other value of host_mode_i leaves the check active.
- R7: At EL2 and EL3 (el_i=2,3), neither trap output is raised.
- R8: With eff_en_i low, the stored hypervisor bits are treated as 0 for trap decisions, while cfg_rdata_o keeps the stored value.
- R9: During a trap, ec_o is 6'h0A and iss_o is 0 for store-with-return, 1 for store-with-zero-status and 2 for plain load/store. Without a trap, ec_o and iss_o are 0.
- R10: insn_cls_i encodes plain=0, return=1, zero-status=2. Code 3, or insn_vld_i low, produces no trap.
- R11: With HAS_FEATURE=0, the enable bits read as 0 and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for hypervisor enable bits |
| cfg_wdata_i | input | 3 | Write data for hypervisor enable bits |
| cfg_rdata_o | output | 3 | Stored hypervisor enable bits |
| eff_en_i | input | 1 | Hypervisor controls effective |
| el_i | input | 2 | Current exception level |
| host_mode_i | input | 2 | Host-mode bit pair |
| guest_en_i | input | 3 | Guest-level enable bits |
| insn_vld_i | input | 1 | Instruction valid |
| insn_cls_i | input | 2 | Instruction class |
| trap_el1_o | output | 1 | Trap to EL1 |
| trap_el2_o | output | 1 | Trap to EL2 |
| ec_o | output | 6 | Exception class |
| iss_o | output | 25 | Syndrome value |

## Verification
The configuration register is the only state in the block. A wrong stored bit appears on cfg_rdata_o one cycle after the write. The same wrong bit shows in the trap decision on the first valid instruction of the affected class at EL1, in the same cycle that instruction is presented. Because the bit-to-class mapping is easy to permute, the vectors exercise each class separately with a single cleared bit. Checking the syndrome code with each trap also exposes a class decode that maps to the wrong bit or the wrong code.

// File: rtl/atd_pkg.sv
package atd_pkg;
  localparam int unsigned NUM_CLS = 3;
  localparam int unsigned EC_W    = 6;
  localparam int unsigned ISS_W   = 25;
  localparam logic [EC_W-1:0] EC_ACCEL64 = 6'h0A;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_RET   = 2'd1,
    CLS_ZST   = 2'd2,
    CLS_RSVD  = 2'd3
  } insn_cls_e;

  typedef enum logic [1:0] {
    LVL_EL0 = 2'd0,
    LVL_EL1 = 2'd1,
    LVL_EL2 = 2'd2,
    LVL_EL3 = 2'd3
  } lvl_e;

  // enable-bit position owned by each class
  function automatic insn_cls_e cls_of_bit(input int unsigned b);
    case (b)
      0:       return CLS_ZST;
      1:       return CLS_PLAIN;
      default: return CLS_RET;
    endcase
  endfunction

  function automatic logic [ISS_W-1:0] iss_of_cls(input insn_cls_e c);
    case (c)
      CLS_RET:   return ISS_W'(0);
      CLS_ZST:   return ISS_W'(1);
      CLS_PLAIN: return ISS_W'(2);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/atd_cfg_reg.sv
module atd_cfg_reg #(
  parameter int unsigned W           = 3,
  parameter bit          HAS_FEATURE = 1'b1,
  parameter bit          HAS_EL3     = 1'b0,
  parameter logic [W-1:0] RST_VAL    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  // without EL3 the warm-reset value is architecturally zero
  localparam logic [W-1:0] RST_EFF = HAS_EL3 ? RST_VAL : '0;

  generate
    if (HAS_FEATURE) begin : g_store
      logic [W-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q_q <= RST_EFF;
        else if (we_i) q_q <= wdata_i;
      end
      assign q_o = q_q;
    end else begin : g_absent
      logic unused;
      assign unused = clk_i ^ rst_ni ^ we_i ^ (^wdata_i);
      assign q_o = '0;
    end
  endgenerate
endmodule

// File: rtl/atd_class_dec.sv
module atd_class_dec
  import atd_pkg::*;
(
  input  logic              vld_i,
  input  insn_cls_e         cls_i,
  output logic [NUM_CLS-1:0] sel_o,
  output logic [ISS_W-1:0]  iss_o
);
  generate
    for (genvar b = 0; b < NUM_CLS; b++) begin : g_sel
      localparam insn_cls_e BC = cls_of_bit(b);
      assign sel_o[b] = vld_i && (cls_i == BC);
    end
  endgenerate

  assign iss_o = iss_of_cls(cls_i);
endmodule

// File: rtl/atd_arbiter.sv
module atd_arbiter
  import atd_pkg::*;
(
  input  lvl_e               el_i,
  input  logic [1:0]         host_mode_i,
  input  logic               eff_en_i,
  input  logic [NUM_CLS-1:0] hyp_en_i,
  input  logic [NUM_CLS-1:0] guest_en_i,
  input  logic [NUM_CLS-1:0] sel_i,
  input  logic [ISS_W-1:0]   iss_i,
  output logic               trap_el1_o,
  output logic               trap_el2_o,
  output logic [EC_W-1:0]    ec_o,
  output logic [ISS_W-1:0]   iss_o
);
  logic [NUM_CLS-1:0] hyp_eff;
  logic active, low_el, guest_hit, hyp_hit, any;

  always_comb begin
    hyp_eff    = eff_en_i ? hyp_en_i : '0;
    active     = (host_mode_i != 2'b11) && (|sel_i);
    low_el     = (el_i == LVL_EL0) || (el_i == LVL_EL1);
    guest_hit  = (el_i == LVL_EL0) && |(sel_i & ~guest_en_i);
    hyp_hit    = low_el && |(sel_i & ~hyp_eff);
    trap_el1_o = active && guest_hit;
    trap_el2_o = active && hyp_hit && !guest_hit;
    any        = trap_el1_o || trap_el2_o;
    ec_o       = any ? EC_ACCEL64 : '0;
    iss_o      = any ? iss_i : '0;
  end
endmodule

// File: rtl/acc_trap_decider.sv
module acc_trap_decider
  import atd_pkg::*;
#(
  parameter bit HAS_FEATURE = 1'b1,
  parameter bit HAS_EL3     = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [2:0]   cfg_wdata_i,
  output logic [2:0]   cfg_rdata_o,
  input  logic         eff_en_i,
  input  logic [1:0]   el_i,
  input  logic [1:0]   host_mode_i,
  input  logic [2:0]   guest_en_i,
  input  logic         insn_vld_i,
  input  logic [1:0]   insn_cls_i,
  output logic         trap_el1_o,
  output logic         trap_el2_o,
  output logic [5:0]   ec_o,
  output logic [24:0]  iss_o
);
  logic [NUM_CLS-1:0] hyp_en, sel;
  logic [ISS_W-1:0]   iss_raw;

  atd_cfg_reg #(
    .W(NUM_CLS), .HAS_FEATURE(HAS_FEATURE), .HAS_EL3(HAS_EL3), .RST_VAL('0)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .q_o(hyp_en)
  );

  atd_class_dec u_dec (
    .vld_i(insn_vld_i), .cls_i(insn_cls_e'(insn_cls_i)),
    .sel_o(sel), .iss_o(iss_raw)
  );

  atd_arbiter u_arb (
    .el_i(lvl_e'(el_i)), .host_mode_i(host_mode_i), .eff_en_i(eff_en_i),
    .hyp_en_i(hyp_en), .guest_en_i(guest_en_i), .sel_i(sel), .iss_i(iss_raw),
    .trap_el1_o(trap_el1_o), .trap_el2_o(trap_el2_o),
    .ec_o(ec_o), .iss_o(iss_o)
  );

  assign cfg_rdata_o = hyp_en;
endmodule

// File: rtl/acc_trap_decider_chk.sv
module acc_trap_decider_chk #(
  parameter bit HAS_FEATURE = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [2:0]  cfg_wdata_i,
  input logic [2:0]  cfg_rdata_o,
  input logic        eff_en_i,
  input logic [1:0]  el_i,
  input logic [1:0]  host_mode_i,
  input logic [2:0]  guest_en_i,
  input logic        insn_vld_i,
  input logic [1:0]  insn_cls_i,
  input logic        trap_el1_o,
  input logic        trap_el2_o,
  input logic [5:0]  ec_o,
  input logic [24:0] iss_o
);
  localparam logic [2:0] MASK = HAS_FEATURE ? 3'b111 : 3'b000;
  logic [1:0] bit_idx;
  logic hyp_bit;
  assign bit_idx = (insn_cls_i == 2'd0) ? 2'd1 : (insn_cls_i == 2'd1) ? 2'd2 : 2'd0;
  assign hyp_bit = cfg_rdata_o[bit_idx];

  // R2 / R11
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == ($past(cfg_wdata_i) & MASK));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_rdata_o));
  // R3
  a_r3_el1_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_i == 2'd1 && insn_vld_i && insn_cls_i != 2'd3 && host_mode_i != 2'b11
     && eff_en_i && !hyp_bit) |-> trap_el2_o);
  // R5
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_el1_o && trap_el2_o));
  a_r5_el1_only_at_el0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_el1_o |-> el_i == 2'd0);
  // R6
  a_r6_host_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_mode_i == 2'b11 |-> !(trap_el1_o || trap_el2_o));
  // R7
  a_r7_high_el: assert property (@(posedge clk_i) disable iff (!rst_ni)
    el_i[1] |-> !(trap_el1_o || trap_el2_o));
  // R9
  a_r9_ec_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_el1_o || trap_el2_o) |-> (ec_o == 6'h0A && iss_o <= 25'd2));
  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_el1_o || trap_el2_o) |-> (ec_o == '0 && iss_o == '0));
  // R10
  a_r10_no_insn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!insn_vld_i || insn_cls_i == 2'd3) |-> !(trap_el1_o || trap_el2_o));
endmodule

bind acc_trap_decider acc_trap_decider_chk #(.HAS_FEATURE(HAS_FEATURE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o), .eff_en_i(eff_en_i), .el_i(el_i),
  .host_mode_i(host_mode_i), .guest_en_i(guest_en_i), .insn_vld_i(insn_vld_i),
  .insn_cls_i(insn_cls_i), .trap_el1_o(trap_el1_o), .trap_el2_o(trap_el2_o),
  .ec_o(ec_o), .iss_o(iss_o)
);

// File: tb/acc_trap_decider_tb.sv
module acc_trap_decider_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, we_nf = 1'b0;
  logic [2:0] wdata = '0, rdata, rdata_nf;
  logic eff = 1'b1;
  logic [1:0] el = 2'd1, host = 2'b00, cls = 2'd0;
  logic [2:0] guest = 3'b111;
  logic vld = 1'b1;
  logic t1, t2, t1_nf, t2_nf;
  logic [5:0] ec, ec_nf;
  logic [24:0] iss, iss_nf;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_trap_decider u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .eff_en_i(eff), .el_i(el), .host_mode_i(host),
    .guest_en_i(guest), .insn_vld_i(vld), .insn_cls_i(cls),
    .trap_el1_o(t1), .trap_el2_o(t2), .ec_o(ec), .iss_o(iss));

  acc_trap_decider #(.HAS_FEATURE(1'b0)) u_dut_nf (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we_nf), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata_nf), .eff_en_i(eff), .el_i(el), .host_mode_i(host),
    .guest_en_i(guest), .insn_vld_i(vld), .insn_cls_i(cls),
    .trap_el1_o(t1_nf), .trap_el2_o(t2_nf), .ec_o(ec_nf), .iss_o(iss_nf));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  // {el, cls, host, eff, hyp, guest, exp_t1, exp_t2, exp_iss}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {2'd1, 2'd0, 2'b00, 1'b1, 3'b101, 3'b111, 1'b0, 1'b1, 2'd2}, // R3 plain
    {2'd1, 2'd1, 2'b00, 1'b1, 3'b011, 3'b111, 1'b0, 1'b1, 2'd0}, // R3 return
    {2'd1, 2'd2, 2'b00, 1'b1, 3'b110, 3'b111, 1'b0, 1'b1, 2'd1}, // R3 zero-status
    {2'd1, 2'd0, 2'b00, 1'b1, 3'b111, 3'b111, 1'b0, 1'b0, 2'd0}, // R4
    {2'd1, 2'd0, 2'b00, 1'b1, 3'b000, 3'b000, 1'b0, 1'b1, 2'd2}, // R3 guest ignored
    {2'd0, 2'd0, 2'b00, 1'b1, 3'b000, 3'b101, 1'b1, 1'b0, 2'd2}, // R5 guest first
    {2'd0, 2'd0, 2'b00, 1'b1, 3'b000, 3'b111, 1'b0, 1'b1, 2'd2}, // R5 hyp
    {2'd0, 2'd2, 2'b00, 1'b1, 3'b111, 3'b110, 1'b1, 1'b0, 2'd1}, // R5
    {2'd0, 2'd1, 2'b00, 1'b1, 3'b111, 3'b111, 1'b0, 1'b0, 2'd0}, // R4
    {2'd0, 2'd0, 2'b11, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0}, // R6
    {2'd1, 2'd0, 2'b10, 1'b1, 3'b000, 3'b111, 1'b0, 1'b1, 2'd2}, // R6 other pair
    {2'd2, 2'd0, 2'b00, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0}, // R7
    {2'd3, 2'd1, 2'b00, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0}, // R7
    {2'd1, 2'd0, 2'b00, 1'b0, 3'b111, 3'b111, 1'b0, 1'b1, 2'd2}, // R8
    {2'd0, 2'd1, 2'b00, 1'b0, 3'b111, 3'b111, 1'b0, 1'b1, 2'd0}, // R8
    {2'd1, 2'd3, 2'b00, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0}  // R10
  };

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", 32'(rdata), 32'h0);
    el = 2'd1; cls = 2'd0; host = 2'b00; eff = 1'b1; guest = 3'b111; vld = 1'b1;
    #1;
    check("R1 trap_el2", 32'(t2), 32'h1);

    // R2 write/readback, bit mapping
    wr(3'b010);
    check("R2 rdata", 32'(rdata), 32'h2);
    cls = 2'd0; #1; check("R2 plain bit1 no trap", 32'(t2), 32'h0);
    cls = 2'd2; #1; check("R2 zst bit0 traps", 32'(t2), 32'h1);
    @(negedge clk); @(negedge clk);
    check("R2 hold", 32'(rdata), 32'h2);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      logic any;
      v = VEC[i];
      wr(v[9:7]);
      el = v[16:15]; cls = v[14:13]; host = v[12:11]; eff = v[10];
      guest = v[6:4]; vld = 1'b1;
      #1;
      any = v[3] | v[2];
      check($sformatf("R5 vec%0d trap_el1", i), 32'(t1), 32'(v[3]));
      check($sformatf("R3 vec%0d trap_el2", i), 32'(t2), 32'(v[2]));
      check($sformatf("R9 vec%0d ec", i), 32'(ec), any ? 32'h0A : 32'h0);
      check($sformatf("R9 vec%0d iss", i), 32'(iss), 32'(v[1:0]));
    end

    // R8 readback unaffected by eff_en
    wr(3'b101);
    eff = 1'b0; #1;
    check("R8 rdata with eff low", 32'(rdata), 32'h5);
    eff = 1'b1;

    // R10 invalid instruction
    wr(3'b000);
    el = 2'd0; guest = 3'b000; host = 2'b00; cls = 2'd0; vld = 1'b0; #1;
    check("R10 vld low el1", 32'(t1), 32'h0);
    check("R10 vld low el2", 32'(t2), 32'h0);
    vld = 1'b1;

    // R11 feature absent
    @(negedge clk); we_nf = 1'b1; wdata = 3'b111;
    @(negedge clk); we_nf = 1'b0;
    check("R11 rdata", 32'(rdata_nf), 32'h0);
    el = 2'd1; cls = 2'd0; guest = 3'b111; #1;
    check("R11 acts as zero", 32'(t2_nf), 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule